// File: doc/BRIEF.md
# Masked interrupt status aggregator

This block gathers event indications from the FIFO and transfer logic of a serial controller into a status register and drives one level-sensitive interrupt line. It holds three registers behind a 32-bit word register port. The status register latches the events. The enable register selects which status bits may raise the interrupt. A global enable bit gates the whole output. Software acknowledges an event by writing a 1 to its status bit. That write toggles the bit rather than clearing it, so writing the same value twice restores the bit.

There are two kinds of event input. Pulse events are overrun, transmit empty, transmit half-empty and transmit underrun; each pulse sets its bit, and the bit stays set until software toggles it off. Level conditions are receive not-empty and receive full; they are ORed into status in every cycle that has a register access (read or write) while the condition holds, so a level bit comes back after acknowledgement as long as its cause remains. The register port has no back-pressure: an access is a single cycle, and read data is combinational from the address in that cycle. There is no streaming data path, so every pin is a plain control or status pin.

Top module: `isr_agg`

## Requirements
- R1: After reset, all three registers read 0 and `irq` is 0.
- R2: The global enable register is at byte offset 0x1C, the status register at 0x20 and the enable register at 0x28. Reads of any other offset return 0, and writes to any other offset change no register.
- R3: Status and enable bit positions are: transmit empty bit 2, transmit underrun bit 3, receive full bit 4, receive overrun bit 5, transmit half-empty bit 6 and receive not-empty bit 8. All other status and enable bits read 0. In the global enable register only bit 31 is stored.
- R4: A write to the status register XORs the written value into the stored status bits.
- R5: A pulse on `ev_rx_overrun`, `ev_tx_empty`, `ev_tx_half` or `ev_tx_underrun` sets its status bit at the next edge. The bit then stays set until software toggles it.
- R6: `ev_rx_nonempty` and `ev_rx_full` set their status bits only at the edge that ends a cycle with a register read or write. Cycles without an access leave those bits unchanged.
- R7: When an event and a status toggle hit the same bit in the same cycle, the bit ends up set.
- R8: `irq` is registered. It equals the global enable bit AND'ed with (status AND enable is nonzero), evaluated on the register contents one edge earlier.
- R9: The enable register stores the written value, masked to the bits in R3, and keeps it until it is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W (7) | Byte offset of the accessed word |
| reg_wr | input | 1 | Write strobe, one access per cycle |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| ev_rx_nonempty | input | 1 | Level: receive FIFO holds data |
| ev_rx_full | input | 1 | Level: receive FIFO is full |
| ev_rx_overrun | input | 1 | Pulse: receive data was lost |
| ev_tx_empty | input | 1 | Pulse: transmit FIFO drained |
| ev_tx_half | input | 1 | Pulse: transmit FIFO reached half-empty |
| ev_tx_underrun | input | 1 | Pulse: transmit underrun |
| irq | output | 1 | Level interrupt request |

## Verification
The bench walks every status bit through its set, hold, toggle-off and toggle-on sequence. A design that cleared on write instead of toggling would fail the second toggle. A design that lost sticky state would fail the hold reads. The bench holds a level condition across idle cycles and expects no change until an access occurs, which catches an implementation that samples levels every cycle. The bench drives an event and a toggle into the same bit in the same cycle, which catches a design where the toggle takes priority. It sweeps every enable bit with the global enable off and on, and checks that `irq` moves exactly one edge after the registers, which catches wrong masking or combinational gating.

// File: rtl/isr_agg_pkg.sv
package isr_agg_pkg;
  localparam int unsigned DATA_W = 32;

  localparam logic [6:0] OFS_GIE  = 7'h1C;
  localparam logic [6:0] OFS_STAT = 7'h20;
  localparam logic [6:0] OFS_EN   = 7'h28;

  localparam int unsigned B_TX_EMPTY   = 2;
  localparam int unsigned B_TX_UNDER   = 3;
  localparam int unsigned B_RX_FULL    = 4;
  localparam int unsigned B_RX_OVER    = 5;
  localparam int unsigned B_TX_HALF    = 6;
  localparam int unsigned B_RX_NEMPTY  = 8;
  localparam int unsigned B_GIE        = 31;

  localparam logic [DATA_W-1:0] STAT_MASK =
    (DATA_W'(1) << B_TX_EMPTY) | (DATA_W'(1) << B_TX_UNDER) |
    (DATA_W'(1) << B_RX_FULL)  | (DATA_W'(1) << B_RX_OVER)  |
    (DATA_W'(1) << B_TX_HALF)  | (DATA_W'(1) << B_RX_NEMPTY);

  function automatic logic [DATA_W-1:0] place(input logic bit_v, input int unsigned pos);
    return bit_v ? (DATA_W'(1) << pos) : '0;
  endfunction
endpackage

// File: rtl/isr_stat_reg.sv
module isr_stat_reg
  import isr_agg_pkg::*;
#(
  parameter logic [DATA_W-1:0] MASK = STAT_MASK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tgl_en,
  input  logic [DATA_W-1:0] tgl_val,
  input  logic [DATA_W-1:0] pulse_vec,
  input  logic [DATA_W-1:0] level_vec,
  input  logic              access,
  output logic [DATA_W-1:0] stat_q
);
  logic [DATA_W-1:0] toggled;
  logic [DATA_W-1:0] set_vec;
  logic [DATA_W-1:0] stat_d;

  always_comb begin
    toggled = tgl_en ? (stat_q ^ tgl_val) : stat_q;
    set_vec = pulse_vec | (access ? level_vec : '0);
    // events are applied after the toggle so a collision leaves the bit set
    stat_d  = (toggled | set_vec) & MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end
endmodule

// File: rtl/isr_irq_gate.sv
module isr_irq_gate
  import isr_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] stat,
  input  logic [DATA_W-1:0] en,
  input  logic              gie,
  output logic              irq_q
);
  logic hit;

  always_comb hit = gie && (|(stat & en));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= hit;
  end
endmodule

// File: rtl/isr_agg.sv
module isr_agg
  import isr_agg_pkg::*;
#(
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ev_rx_nonempty,
  input  logic              ev_rx_full,
  input  logic              ev_rx_overrun,
  input  logic              ev_tx_empty,
  input  logic              ev_tx_half,
  input  logic              ev_tx_underrun,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_GIE  = ADDR_W'(OFS_GIE);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_EN);

  logic              sel_gie, sel_stat, sel_en;
  logic [DATA_W-1:0] stat_q;
  logic [DATA_W-1:0] en_q;
  logic              gie_q;
  logic [DATA_W-1:0] pulse_vec;
  logic [DATA_W-1:0] level_vec;

  always_comb begin
    sel_gie  = (reg_addr == A_GIE);
    sel_stat = (reg_addr == A_STAT);
    sel_en   = (reg_addr == A_EN);
  end

  always_comb begin
    pulse_vec = place(ev_rx_overrun, B_RX_OVER) | place(ev_tx_empty, B_TX_EMPTY) |
                place(ev_tx_half, B_TX_HALF)    | place(ev_tx_underrun, B_TX_UNDER);
    level_vec = place(ev_rx_nonempty, B_RX_NEMPTY) | place(ev_rx_full, B_RX_FULL);
  end

  isr_stat_reg #(.MASK(STAT_MASK)) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .tgl_en    (reg_wr && sel_stat),
    .tgl_val   (reg_wdata),
    .pulse_vec (pulse_vec),
    .level_vec (level_vec),
    .access    (reg_wr || reg_rd),
    .stat_q    (stat_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      gie_q <= 1'b0;
    end else if (reg_wr) begin
      if (sel_en)  en_q  <= reg_wdata & STAT_MASK;
      if (sel_gie) gie_q <= reg_wdata[B_GIE];
    end
  end

  always_comb begin
    unique case (1'b1)
      sel_gie:  reg_rdata = place(gie_q, B_GIE);
      sel_stat: reg_rdata = stat_q;
      sel_en:   reg_rdata = en_q;
      default:  reg_rdata = '0;
    endcase
  end

  isr_irq_gate u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .stat  (stat_q),
    .en    (en_q),
    .gie   (gie_q),
    .irq_q (irq)
  );
endmodule

// File: rtl/isr_agg_chk.sv
module isr_agg_chk
  import isr_agg_pkg::*;
#(
  parameter int unsigned ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              ev_rx_nonempty,
  input logic              ev_tx_empty,
  input logic              ev_rx_overrun,
  input logic              irq,
  input logic [DATA_W-1:0] stat_q,
  input logic [DATA_W-1:0] en_q,
  input logic              gie_q
);
  logic wr_stat, wr_en;
  assign wr_stat = reg_wr && (reg_addr == ADDR_W'(OFS_STAT));
  assign wr_en   = reg_wr && (reg_addr == ADDR_W'(OFS_EN));

  assert_pulse_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_overrun |=> stat_q[B_RX_OVER]);

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[B_RX_OVER] && !(wr_stat && reg_wdata[B_RX_OVER])) |=> stat_q[B_RX_OVER]);

  assert_level_on_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_wr || reg_rd) && ev_rx_nonempty) |=> stat_q[B_RX_NEMPTY]);

  assert_no_access_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && !reg_rd) |=> $stable(stat_q[B_RX_NEMPTY]));

  assert_collision_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tx_empty && wr_stat && reg_wdata[B_TX_EMPTY]) |=> stat_q[B_TX_EMPTY]);

  assert_gie_off_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_q |=> !irq);

  assert_en_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_q));
endmodule

bind isr_agg isr_agg_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .reg_addr       (reg_addr),
  .reg_wr         (reg_wr),
  .reg_rd         (reg_rd),
  .reg_wdata      (reg_wdata),
  .ev_rx_nonempty (ev_rx_nonempty),
  .ev_tx_empty    (ev_tx_empty),
  .ev_rx_overrun  (ev_rx_overrun),
  .irq            (irq),
  .stat_q         (stat_q),
  .en_q           (en_q),
  .gie_q          (gie_q)
);

// File: tb/isr_agg_tb.sv
module isr_agg_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] MASK = 32'h0000_017C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic ev_rx_nonempty = 0, ev_rx_full = 0, ev_rx_overrun = 0;
  logic ev_tx_empty = 0, ev_tx_half = 0, ev_tx_underrun = 0;
  logic irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  isr_agg u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_rx_nonempty(ev_rx_nonempty), .ev_rx_full(ev_rx_full), .ev_rx_overrun(ev_rx_overrun),
    .ev_tx_empty(ev_tx_empty), .ev_tx_half(ev_tx_half), .ev_tx_underrun(ev_tx_underrun),
    .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [6:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  // drive the event that sets status bit b for one cycle; levels need an access
  task automatic fire(input int b);
    logic [31:0] v;
    case (b)
      2: ev_tx_empty = 1;
      3: ev_tx_underrun = 1;
      4: ev_rx_full = 1;
      5: ev_rx_overrun = 1;
      6: ev_tx_half = 1;
      default: ev_rx_nonempty = 1;
    endcase
    if (b == 4 || b == 8) rd(7'h00, v);
    else @(negedge clk);
    {ev_rx_nonempty, ev_rx_full, ev_rx_overrun, ev_tx_empty, ev_tx_half, ev_tx_underrun} = '0;
  endtask

  initial begin
    repeat (20000) @(negedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int bits[6] = '{2, 3, 4, 5, 6, 8};
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    rd_chk("R1 gie", 7'h1C, 32'h0);
    rd_chk("R1 stat", 7'h20, 32'h0);
    rd_chk("R1 en", 7'h28, 32'h0);

    // R5/R6/R4 per-bit set, hold, toggle sequence
    foreach (bits[i]) begin
      logic [31:0] m;
      m = 32'h1 << bits[i];
      fire(bits[i]);
      rd_chk($sformatf("R5 R6 set bit %0d", bits[i]), 7'h20, m);
      repeat (3) @(negedge clk);
      rd_chk($sformatf("R5 sticky bit %0d", bits[i]), 7'h20, m);
      wr(7'h20, m);
      rd_chk($sformatf("R4 toggle off bit %0d", bits[i]), 7'h20, 32'h0);
      wr(7'h20, m);
      rd_chk($sformatf("R4 toggle on bit %0d", bits[i]), 7'h20, m);
      wr(7'h20, m);
      rd_chk($sformatf("R4 clear again bit %0d", bits[i]), 7'h20, 32'h0);
    end

    // R6 level held without access leaves status alone
    ev_rx_nonempty = 1;
    repeat (3) @(negedge clk);
    rd(7'h20, v);
    check("R6 no access no set", v, 32'h0);
    ev_rx_nonempty = 0;
    rd_chk("R6 set by access", 7'h20, 32'h100);
    ev_rx_full = 1;
    wr(7'h20, 32'h100);
    ev_rx_full = 0;
    rd_chk("R6 write access sets full, toggle clears nonempty", 7'h20, 32'h10);
    wr(7'h20, 32'h10);

    // R6 level re-asserts immediately after acknowledgement while still true
    ev_rx_nonempty = 1;
    rd(7'h00, v);
    wr(7'h20, 32'h100);
    ev_rx_nonempty = 0;
    rd_chk("R6 reassert on ack write", 7'h20, 32'h100);
    wr(7'h20, 32'h100);
    rd_chk("R6 ack after level gone", 7'h20, 32'h0);

    // R3/R4 full-word xor limited to implemented bits
    wr(7'h20, 32'hFFFF_FFFF);
    rd_chk("R3 R4 xor all", 7'h20, MASK);
    wr(7'h20, 32'h0000_0104);
    rd_chk("R4 partial xor", 7'h20, MASK & ~32'h104);
    wr(7'h20, MASK & ~32'h104);
    rd_chk("R4 back to zero", 7'h20, 32'h0);

    // R7 collisions: set bit toggled with event, and clear bit toggled with event
    wr(7'h20, 32'h4);
    ev_tx_empty = 1;
    wr(7'h20, 32'h4);
    ev_tx_empty = 0;
    rd_chk("R7 event beats toggle-off", 7'h20, 32'h4);
    ev_rx_overrun = 1;
    wr(7'h20, 32'h20);
    ev_rx_overrun = 0;
    rd_chk("R7 event with toggle-on", 7'h20, 32'h24);
    wr(7'h20, 32'h24);

    // R2 unmapped offsets
    wr(7'h28, 32'h0000_0008);
    wr(7'h24, 32'hFFFF_FFFF);
    wr(7'h40, 32'hFFFF_FFFF);
    rd_chk("R2 unmapped read", 7'h24, 32'h0);
    rd_chk("R2 unmapped write ignored en", 7'h28, 32'h8);
    rd_chk("R2 unmapped write ignored stat", 7'h20, 32'h0);
    rd_chk("R2 unmapped write ignored gie", 7'h1C, 32'h0);

    // R9/R3 register storage masking
    wr(7'h28, 32'hFFFF_FFFF);
    rd_chk("R9 en masked", 7'h28, MASK);
    wr(7'h1C, 32'hFFFF_FFFF);
    rd_chk("R3 gie only bit31", 7'h1C, 32'h8000_0000);
    wr(7'h1C, 32'h7FFF_FFFF);
    rd_chk("R3 gie cleared", 7'h1C, 32'h0);

    // R8 sweep: gie x each enable bit x status match/mismatch
    for (int g = 0; g < 2; g++) begin
      foreach (bits[i]) begin
        logic [31:0] m;
        m = 32'h1 << bits[i];
        wr(7'h1C, g ? 32'h8000_0000 : 32'h0);
        wr(7'h28, MASK & ~m);
        wr(7'h20, m);
        @(negedge clk);
        check($sformatf("R8 masked bit %0d gie %0d", bits[i], g), {31'b0, irq}, 32'h0);
        wr(7'h28, m);
        check($sformatf("R8 one edge latency bit %0d", bits[i]), {31'b0, irq}, 32'h0);
        @(negedge clk);
        check($sformatf("R8 irq bit %0d gie %0d", bits[i], g), {31'b0, irq}, g);
        wr(7'h20, m);
        @(negedge clk);
        check($sformatf("R8 irq drops bit %0d", bits[i]), {31'b0, irq}, 32'h0);
      end
    end

    // R8 dropping global enable removes irq one edge later
    wr(7'h28, MASK);
    wr(7'h20, MASK);
    @(negedge clk);
    check("R8 all set", {31'b0, irq}, 32'h1);
    wr(7'h1C, 32'h0);
    check("R8 gie off latency", {31'b0, irq}, 32'h1);
    @(negedge clk);
    check("R8 gie off", {31'b0, irq}, 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule